// File: doc/BRIEF.md
# Clock Failure Monitor

This block watches a monitored clock and raises a flag when that clock stops toggling. A free-running reference clock drives a binary divider. The divider's most significant bit is a slow sample clock, and its period is 2^DIV_W reference cycles. A monitor latch gets two opposing events. The start of every sample high phase clears it. Every falling edge of the monitored clock sets it. When the sample high phase ends, the latch is tested. If no monitored falling edge arrived during the phase, the latch is still clear and the clock is judged dead.

The monitored-clock domain holds only a toggle flop, which flips on each falling edge. The reference domain synchronises that toggle, turns each change of it into a set event, and keeps the latch, the divider and the failure flag. The failure flag is sticky. It stays set while the monitored clock recovers and drops only on reset or on an explicit clear. The latch state is also brought out, so the sampling rhythm can be observed at the ports.

Top module: `clk_fail_mon`

## Requirements
- R1: While reset is asserted, and until the first active reference edge after its synchronised release, `fail_o` and `latch_o` are both 0.
- R2: On the reference edge where the divider count goes from 2^(DIV_W-1)-1 to 2^(DIV_W-1) (sample clock rising), the latch is cleared. This clear wins over a coinciding set event.
- R3: A falling edge of `mon_clk` sets the latch once the edge has crossed the SYNC_STAGES-deep synchroniser and its edge detector, provided no clear coincides and `mon_en` is 1.
- R4: On the reference edge where the count wraps from 2^DIV_W-1 to 0 (sample clock falling), `fail_o` becomes 1 if the latch is 0. `fail_o` never rises at any other time.
- R5: Once set, `fail_o` holds until `fail_clr` is 1 at a reference edge or reset is asserted. The clear wins over a detection in the same cycle.
- R6: While `mon_en` is 0, the divider is held at count 0 and the latch is held at 0. Monitored edges have no effect, and `fail_o` cannot become 1.
- R7: A monitored clock whose period is shorter than 2^(DIV_W-1)-SYNC_STAGES-2 reference cycles never causes a detection, over at least 16 sample periods and at more than one frequency.
- R8: The sample period is exactly 2^DIV_W reference cycles (64 by default). With a healthy clock, successive clears of the latch are 64 reference cycles apart.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ref_clk | input | 1 | Free-running reference clock that drives the divider and the detection logic |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously in each domain |
| mon_clk | input | 1 | Clock under observation; its falling edges set the monitor latch |
| mon_en | input | 1 | Monitor enable, synchronous to ref_clk |
| fail_clr | input | 1 | Clears the sticky failure flag, synchronous to ref_clk |
| fail_o | output | 1 | Sticky failure-detected flag |
| latch_o | output | 1 | Current monitor latch state |

## Verification
The assertions assume that `mon_en` and `fail_clr` change only with respect to `ref_clk`. They also assume that a working monitored clock runs well inside the sample high phase, so that a set event can cross the synchroniser before the latch is tested. The bench changes both inputs on the falling reference edge. It uses monitored periods of about 5.5 and 16 reference cycles, and it breaks the period bound only by stopping the monitored clock outright. A behavioural model of the count phase, the crossing delay and the sticky flag is compared against both outputs on every reference cycle.

// File: rtl/clkmon_pkg.sv
package clkmon_pkg;
  // Events produced by the sample divider, valid for one reference cycle.
  typedef struct packed {
    logic rise;   // sample clock goes high at the next edge
    logic fall;   // sample clock goes low at the next edge
  } smp_evt_t;
endpackage

// File: rtl/clkmon_sync.sv
module clkmon_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_one
      always_comb chain_d = d;
    end else begin : g_many
      always_comb chain_d = {chain_q[STAGES-2:0], d};
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/clkmon_divider.sv
module clkmon_divider
  import clkmon_pkg::*;
#(
  parameter int DIV_W = 6
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     en,
  output smp_evt_t evt
);
  localparam logic [DIV_W-1:0] LAST_CNT = '1;
  localparam logic [DIV_W-1:0] HALF_M1  = {1'b0, {(DIV_W-1){1'b1}}};

  logic [DIV_W-1:0] cnt_q;
  logic [DIV_W-1:0] cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (en) cnt_d = cnt_q + 1'b1;
    else    cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  always_comb begin
    evt.rise = en && (cnt_q == HALF_M1);
    evt.fall = en && (cnt_q == LAST_CNT);
  end

  // The sample clock (count MSB) follows the events one edge later.
  assert_rise_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.rise |=> cnt_q[DIV_W-1]);
  assert_fall_edge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    evt.fall |=> !cnt_q[DIV_W-1]);
  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !cnt_q[DIV_W-1]);
endmodule

// File: rtl/clkmon_latch.sv
module clkmon_latch #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tog_async,
  input  logic en,
  input  logic clr_evt,
  output logic latch_q
);
  logic tog_s;
  logic tog_prev_q;
  logic mon_edge;
  logic latch_d;

  clkmon_sync #(.STAGES(SYNC_STAGES)) u_tog_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (tog_async),
    .q    (tog_s)
  );

  always_comb begin
    mon_edge = tog_s ^ tog_prev_q;
    latch_d  = latch_q;
    if (!en)          latch_d = 1'b0;
    else if (clr_evt) latch_d = 1'b0;   // clear beats a coinciding set
    else if (mon_edge) latch_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tog_prev_q <= 1'b0;
      latch_q    <= 1'b0;
    end else begin
      tog_prev_q <= tog_s;
      latch_q    <= latch_d;
    end
  end

  assert_clear_on_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clr_evt |=> !latch_q);
  assert_set_on_edge_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en && mon_edge && !clr_evt) |=> latch_q);
  assert_idle_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !latch_q);
endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon
  import clkmon_pkg::*;
#(
  parameter int DIV_W       = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic mon_clk,
  input  logic mon_en,
  input  logic fail_clr,
  output logic fail_o,
  output logic latch_o
);
  logic     ref_rst_n;
  logic     mon_rst_n;
  logic     mon_clk_n;
  logic     tog_q;
  logic     tog_d;
  logic     latch_q;
  logic     fail_q;
  logic     fail_d;
  smp_evt_t evt;

  assign mon_clk_n = ~mon_clk;

  clkmon_sync #(.STAGES(2)) u_rst_ref (
    .clk(ref_clk), .rst_n(rst_n), .d(1'b1), .q(ref_rst_n)
  );

  clkmon_sync #(.STAGES(2)) u_rst_mon (
    .clk(mon_clk_n), .rst_n(rst_n), .d(1'b1), .q(mon_rst_n)
  );

  // Monitored domain: flips on every falling edge of mon_clk.
  always_comb tog_d = ~tog_q;

  always_ff @(posedge mon_clk_n or negedge mon_rst_n) begin
    if (!mon_rst_n) tog_q <= 1'b0;
    else            tog_q <= tog_d;
  end

  clkmon_divider #(.DIV_W(DIV_W)) u_div (
    .clk  (ref_clk),
    .rst_n(ref_rst_n),
    .en   (mon_en),
    .evt  (evt)
  );

  clkmon_latch #(.SYNC_STAGES(SYNC_STAGES)) u_latch (
    .clk      (ref_clk),
    .rst_n    (ref_rst_n),
    .tog_async(tog_q),
    .en       (mon_en),
    .clr_evt  (evt.rise),
    .latch_q  (latch_q)
  );

  always_comb begin
    fail_d = fail_q;
    if (fail_clr)                  fail_d = 1'b0;
    else if (evt.fall && !latch_q) fail_d = 1'b1;
  end

  always_ff @(posedge ref_clk or negedge ref_rst_n) begin
    if (!ref_rst_n) fail_q <= 1'b0;
    else            fail_q <= fail_d;
  end

  assign fail_o  = fail_q;
  assign latch_o = latch_q;

  assert_fail_cause_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    $rose(fail_q) |-> $past(evt.fall && !latch_q));
  assert_detect_R4: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (evt.fall && !latch_q && !fail_clr) |=> fail_q);
  assert_sticky_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    (fail_q && !fail_clr) |=> fail_q);
  assert_clear_R5: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    fail_clr |=> !fail_q);
  assert_no_detect_idle_R6: assert property (@(posedge ref_clk) disable iff (!ref_rst_n)
    !mon_en |=> !$rose(fail_q));
endmodule

// File: tb/clk_fail_mon_tb_top.sv
`timescale 1ns/1ps
module clk_fail_mon_tb_top;
  logic ref_clk;
  logic rst_n;
  logic mon_clk;
  logic mon_en;
  logic fail_clr;
  logic fail_o;
  logic latch_o;

  int  n_checks = 0;
  int  n_fail   = 0;
  int  cyc      = 0;
  bit  mon_run  = 1'b1;
  real mon_half = 13.7;
  bit  finished = 1'b0;

  clk_fail_mon dut_i (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .mon_clk (mon_clk),
    .mon_en  (mon_en),
    .fail_clr(fail_clr),
    .fail_o  (fail_o),
    .latch_o (latch_o)
  );

  // 200 MHz reference clock
  initial begin
    ref_clk = 1'b0;
    forever #2.5 ref_clk = ~ref_clk;
  end

  // Independent monitored clock that can be frozen
  initial begin
    mon_clk = 1'b1;
    forever begin
      #(mon_half);
      if (mon_run) mon_clk = ~mon_clk;
    end
  end

  always @(posedge ref_clk) cyc <= cyc + 1;

  // ---------------- behavioural reference model ----------------
  bit mtog;
  int mrc;
  always @(negedge mon_clk) begin
    if (!rst_n) begin
      mrc <= 0;
    end else begin
      if (mrc >= 2) mtog <= ~mtog;
      mrc <= mrc + 1;
    end
  end

  int  rcnt;
  int  ph;
  bit  m_lat;
  bit  m_fail;
  bit  hist[$];
  always @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      rcnt = 0; ph = 0; m_lat = 0; m_fail = 0;
      hist = '{0, 0, 0};
    end else if (rcnt < 2) begin
      rcnt = rcnt + 1;
    end else begin
      bit seen;
      bit up;
      bit down;
      seen = (hist[1] != hist[2]);
      up   = mon_en && (ph == 31);
      down = mon_en && (ph == 63);
      if (fail_clr)            m_fail = 0;
      else if (down && !m_lat) m_fail = 1;
      if (!mon_en)   m_lat = 0;
      else if (up)   m_lat = 0;
      else if (seen) m_lat = 1;
      ph = mon_en ? (ph + 1) % 64 : 0;
      hist.push_front(mtog);
      void'(hist.pop_back());
    end
  end

  // Compare on every reference cycle, away from the active edge
  always @(negedge ref_clk) begin
    if (!finished) begin
      n_checks++;
      if (fail_o !== m_fail) begin
        n_fail++;
        $display("FAIL R4 cycle %0d: fail_o actual %0b expected %0b", cyc, fail_o, m_fail);
      end
      n_checks++;
      if (latch_o !== m_lat) begin
        n_fail++;
        $display("FAIL R3 cycle %0d: latch_o actual %0b expected %0b", cyc, latch_o, m_lat);
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge ref_clk);
  endtask

  task automatic wait_latch_fall(output int at);
    while (latch_o !== 1'b1) @(negedge ref_clk);
    while (latch_o !== 1'b0) @(negedge ref_clk);
    at = cyc;
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // Watchdog
  initial begin
    for (int i = 0; i < 150000; i++) @(posedge ref_clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d cycles", 150000, 0);
    finish_run();
  end

  initial begin
    int t0;
    int t1;
    rst_n = 1'b0; mon_en = 1'b0; fail_clr = 1'b0;
    wait_cyc(5);
    check(fail_o == 0 && latch_o == 0, "R1 in reset", {fail_o, latch_o}, 0);
    rst_n = 1'b1;
    wait_cyc(4);
    check(fail_o == 0 && latch_o == 0, "R1 after release", {fail_o, latch_o}, 0);

    // R7: fast healthy clock over 20 sample periods
    mon_en = 1'b1;
    wait_cyc(20 * 64);
    check(fail_o == 0, "R7 fast clock", fail_o, 0);

    // R8 and R3: latch set then cleared once per sample period
    wait_latch_fall(t0);
    check(1, "R3 latch observed set", 1, 1);
    wait_latch_fall(t1);
    check(t1 - t0 == 64, "R8 sample period", t1 - t0, 64);
    wait_latch_fall(t0);
    check(t0 - t1 == 64, "R8 sample period again", t0 - t1, 64);

    // R4: stop the monitored clock
    mon_run = 1'b0;
    wait_cyc(3 * 64);
    check(fail_o == 1, "R4 stopped clock detected", fail_o, 1);
    check(latch_o == 0, "R2 latch stays clear", latch_o, 0);

    // R5: sticky after recovery
    mon_run = 1'b1;
    wait_cyc(2 * 64);
    check(fail_o == 1, "R5 sticky after recovery", fail_o, 1);
    fail_clr = 1'b1;
    wait_cyc(1);
    fail_clr = 1'b0;
    check(fail_o == 0, "R5 explicit clear", fail_o, 0);
    wait_cyc(3 * 64);
    check(fail_o == 0, "R5 stays clear when healthy", fail_o, 0);

    // R6: disabled monitor ignores edges and a stopped clock
    mon_en = 1'b0;
    wait_cyc(4);
    check(latch_o == 0, "R6 latch held clear", latch_o, 0);
    wait_cyc(40);
    check(latch_o == 0, "R6 edges ignored", latch_o, 0);
    mon_run = 1'b0;
    wait_cyc(4 * 64);
    check(fail_o == 0, "R6 no detection while disabled", fail_o, 0);
    mon_run = 1'b1;

    // R7: slower but valid clock over 16 sample periods
    mon_half = 40.3;
    wait_cyc(20);
    mon_en = 1'b1;
    wait_cyc(16 * 64 + 8);
    check(fail_o == 0, "R7 slow clock", fail_o, 0);

    // R4 at the slow rate, then R1 reset clears the flag
    mon_run = 1'b0;
    wait_cyc(3 * 64);
    check(fail_o == 1, "R4 slow clock stopped", fail_o, 1);
    rst_n = 1'b0;
    wait_cyc(2);
    check(fail_o == 0 && latch_o == 0, "R1 reset clears flag", {fail_o, latch_o}, 0);
    finish_run();
  end
endmodule